// File: doc/BRIEF.md
# Floating-Point Class Mask with Narrow-Operand Box Validation

This block sorts a 64-bit floating-point register value into one of ten classes and reports the class as a one-hot mask in the low ten bits of a 64-bit result. A mode input chooses between double and single precision.

In single-precision mode the operand occupies the low 32 bits of the register. The upper 32 bits must then all be ones to count as a valid box. If any of those bits is zero, the operand is replaced by the canonical single quiet NaN (0x7FC00000) before it is classified. The result is therefore the quiet-NaN class, whatever the low half holds. In double-precision mode the whole register is the operand and no box test is made.

A companion path wraps a 32-bit value into a 64-bit register value, with all ones above it, for writing narrow results back. Both paths are combinational and share an optional output register, selected by the parameter `REG_OUT`. With `REG_OUT = 1` (the default) the outputs follow the inputs one clock later, and reset clears them.

Top module: `fp_classify`

## Requirements
- R1: The class mask uses these bit positions: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN. Bits 63:10 of `class_o` are always zero.
- R2: An exponent of all zeros gives zero (bit 4 or 3) when the fraction is zero, and subnormal (bit 5 or 2) otherwise. A clear sign bit selects the positive class.
- R3: An exponent of all ones gives infinity (bit 7 or 0) when the fraction is zero. With a nonzero fraction, the top fraction bit set gives quiet NaN (bit 9) and clear gives signaling NaN (bit 8), for either sign.
- R4: Any other exponent gives normal: bit 6 for a clear sign, bit 1 for a set sign.
- R5: With `single_i` = 1 and `src_i[63:32]` all ones, bits 31:0 are classified as a single-precision value: sign bit 31, exponent 30:23, fraction 22:0.
- R6: With `single_i` = 1 and any bit of `src_i[63:32]` zero, the result is bit 9 (quiet NaN), regardless of bits 31:0.
- R7: With `single_i` = 0, all 64 bits are classified as a double-precision value (sign bit 63, exponent 62:52, fraction 51:0) with no box test, whatever the upper half holds.
- R8: `boxed_o` equals `{32'hFFFF_FFFF, box_val_i}`.
- R9: With `REG_OUT` = 1, both outputs change only on a rising clock edge, carrying the inputs present at that edge. While `rst_ni` is low both outputs are zero.
- R10: Outside reset, exactly one of bits 9:0 of `class_o` is set for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Floating-point register value to classify |
| single_i | input | 1 | 1 selects single precision with box test, 0 selects double |
| box_val_i | input | 32 | Narrow value to wrap into a 64-bit register value |
| class_o | output | 64 | One-hot class mask, zero-extended |
| boxed_o | output | 64 | Wrapped value: all ones above `box_val_i` |

## Verification
The classifier is driven with the extreme member of every class in both precisions. These include:
- the largest subnormal against the smallest normal;
- the largest finite value against infinity;
- a one-bit fraction under an all-ones exponent, against the quiet bit;
- NaNs of both signs.

Together these separate each decision boundary from its neighbour. Single-mode operands with a valid box are set against operands whose upper half differs by a single zero bit, which separates box validation from classification. Double-mode operands with junk in the upper half show that no box test runs in that mode. Pseudo-random registers in both modes check that the mask always stays one-hot.

// File: rtl/fp_classify_pkg.sv
package fp_classify_pkg;

    localparam int REG_W     = 64;
    localparam int NARROW_W  = 32;
    localparam int CLS_W     = 10;

    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;

    localparam logic [NARROW_W-1:0] SGL_QNAN = 32'h7FC0_0000;

    localparam int C_NEG_INF  = 0;
    localparam int C_NEG_NORM = 1;
    localparam int C_NEG_SUB  = 2;
    localparam int C_NEG_ZERO = 3;
    localparam int C_POS_ZERO = 4;
    localparam int C_POS_SUB  = 5;
    localparam int C_POS_NORM = 6;
    localparam int C_POS_INF  = 7;
    localparam int C_SNAN     = 8;
    localparam int C_QNAN     = 9;

    typedef struct packed {
        logic [REG_W-1:0] cls;
        logic [REG_W-1:0] boxed;
    } result_t;

endpackage

// File: rtl/fpcls_unbox.sv
module fpcls_unbox
    import fp_classify_pkg::*;
#(
    parameter int WIDE_W = REG_W,
    parameter int THIN_W = NARROW_W,
    parameter logic [THIN_W-1:0] FILL = SGL_QNAN
) (
    input  logic [WIDE_W-1:0] reg_i,
    output logic [THIN_W-1:0] op_o
);

    localparam int HI_W = WIDE_W - THIN_W;

    generate
        if (HI_W > 0) begin : g_check
            logic box_ok;
            assign box_ok = &reg_i[WIDE_W-1:THIN_W];
            assign op_o   = box_ok ? reg_i[THIN_W-1:0] : FILL;
        end else begin : g_pass
            assign op_o = reg_i[THIN_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fpcls_decode.sv
module fpcls_decode
    import fp_classify_pkg::*;
#(
    parameter int EXP_W  = DBL_EXP_W,
    parameter int FRAC_W = DBL_FRAC_W,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic [W-1:0]     val_i,
    output logic [CLS_W-1:0] cls_o
);

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign sgn = val_i[W-1];
    assign ex  = val_i[W-2:FRAC_W];
    assign fr  = val_i[FRAC_W-1:0];

    always_comb begin
        cls_o = '0;
        if (ex == '0) begin
            if (fr == '0) begin
                cls_o[sgn ? C_NEG_ZERO : C_POS_ZERO] = 1'b1;
            end else begin
                cls_o[sgn ? C_NEG_SUB : C_POS_SUB] = 1'b1;
            end
        end else if (&ex) begin
            if (fr == '0) begin
                cls_o[sgn ? C_NEG_INF : C_POS_INF] = 1'b1;
            end else if (fr[FRAC_W-1]) begin
                cls_o[C_QNAN] = 1'b1;
            end else begin
                cls_o[C_SNAN] = 1'b1;
            end
        end else begin
            cls_o[sgn ? C_NEG_NORM : C_POS_NORM] = 1'b1;
        end
    end

endmodule

// File: rtl/fpcls_box.sv
module fpcls_box
    import fp_classify_pkg::*;
#(
    parameter int WIDE_W = REG_W,
    parameter int THIN_W = NARROW_W
) (
    input  logic [THIN_W-1:0] val_i,
    output logic [WIDE_W-1:0] reg_o
);

    assign reg_o = {{(WIDE_W-THIN_W){1'b1}}, val_i};

endmodule

// File: rtl/fp_classify.sv
module fp_classify
    import fp_classify_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [REG_W-1:0]    src_i,
    input  logic                single_i,
    input  logic [NARROW_W-1:0] box_val_i,
    output logic [REG_W-1:0]    class_o,
    output logic [REG_W-1:0]    boxed_o
);

    logic [NARROW_W-1:0] sgl_op;
    logic [CLS_W-1:0]    sgl_cls;
    logic [CLS_W-1:0]    dbl_cls;
    logic [REG_W-1:0]    box_reg;
    result_t             res_d;
    result_t             res_q;

    fpcls_unbox #(.WIDE_W(REG_W), .THIN_W(NARROW_W), .FILL(SGL_QNAN)) u_unbox (
        .reg_i (src_i),
        .op_o  (sgl_op)
    );

    fpcls_decode #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_dec_sgl (
        .val_i (sgl_op),
        .cls_o (sgl_cls)
    );

    fpcls_decode #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_dec_dbl (
        .val_i (src_i),
        .cls_o (dbl_cls)
    );

    fpcls_box #(.WIDE_W(REG_W), .THIN_W(NARROW_W)) u_box (
        .val_i (box_val_i),
        .reg_o (box_reg)
    );

    always_comb begin
        res_d       = '0;
        res_d.cls   = {{(REG_W-CLS_W){1'b0}}, (single_i ? sgl_cls : dbl_cls)};
        res_d.boxed = box_reg;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign class_o = res_q.cls;
    assign boxed_o = res_q.boxed;

endmodule

// File: rtl/fp_classify_chk.sv
module fp_classify_chk
    import fp_classify_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [REG_W-1:0]    src_i,
    input logic                single_i,
    input logic [NARROW_W-1:0] box_val_i,
    input logic [REG_W-1:0]    class_o,
    input logic [REG_W-1:0]    boxed_o
);

    a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        class_o[REG_W-1:CLS_W] == '0);

    generate
        if (REG_OUT) begin : g_seq
            a_r10_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $past(rst_ni) |-> $countones(class_o[CLS_W-1:0]) == 1);

            a_r6_bad_box_qnan: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && $past(single_i) && ($past(src_i[REG_W-1:NARROW_W]) != '1))
                |-> class_o == (64'd1 << C_QNAN));

            a_r8_box_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $past(rst_ni) |-> boxed_o == {32'hFFFF_FFFF, $past(box_val_i)});

            a_r9_reset_clear: assert property (@(posedge clk_i)
                !rst_ni |=> (class_o == '0 && boxed_o == '0));
        end else begin : g_comb
            a_r10_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $countones(class_o[CLS_W-1:0]) == 1);

            a_r6_bad_box_qnan: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (single_i && src_i[REG_W-1:NARROW_W] != '1) |-> class_o == (64'd1 << C_QNAN));

            a_r8_box_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
                boxed_o == {32'hFFFF_FFFF, box_val_i});
        end
    endgenerate

endmodule

bind fp_classify fp_classify_chk #(.REG_OUT(REG_OUT)) u_fp_classify_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_i),
    .single_i  (single_i),
    .box_val_i (box_val_i),
    .class_o   (class_o),
    .boxed_o   (boxed_o)
);

// File: tb/test_fp_classify.sv
module test_fp_classify;

    localparam int NV = 29;
    // {src[63:0], single, expected class[9:0]}
    localparam logic [74:0] VEC [NV] = '{
        {64'hFFF0_0000_0000_0000, 1'b0, 10'h001},  // R3 -inf
        {64'hBFF0_0000_0000_0000, 1'b0, 10'h002},  // R4 neg normal
        {64'h8000_0000_0000_0001, 1'b0, 10'h004},  // R2 neg subnormal
        {64'h8000_0000_0000_0000, 1'b0, 10'h008},  // R2 -0
        {64'h0000_0000_0000_0000, 1'b0, 10'h010},  // R2 +0
        {64'h000F_FFFF_FFFF_FFFF, 1'b0, 10'h020},  // R2 largest subnormal
        {64'h0010_0000_0000_0000, 1'b0, 10'h040},  // R4 smallest normal
        {64'h7FEF_FFFF_FFFF_FFFF, 1'b0, 10'h040},  // R4 largest finite
        {64'h7FF0_0000_0000_0000, 1'b0, 10'h080},  // R3 +inf
        {64'h7FF0_0000_0000_0001, 1'b0, 10'h100},  // R3 sNaN
        {64'hFFF7_FFFF_FFFF_FFFF, 1'b0, 10'h100},  // R3 negative sNaN
        {64'hFFF8_0000_0000_0000, 1'b0, 10'h200},  // R3 negative qNaN
        {64'h0000_0000_7F80_0000, 1'b0, 10'h020},  // R7 upper junk ignored
        {64'hFFFF_FFFF_FF80_0000, 1'b1, 10'h001},  // R5 -inf
        {64'hFFFF_FFFF_BF80_0000, 1'b1, 10'h002},  // R5 neg normal
        {64'hFFFF_FFFF_8000_0001, 1'b1, 10'h004},  // R5 neg sub
        {64'hFFFF_FFFF_8000_0000, 1'b1, 10'h008},  // R5 -0
        {64'hFFFF_FFFF_0000_0000, 1'b1, 10'h010},  // R5 +0
        {64'hFFFF_FFFF_007F_FFFF, 1'b1, 10'h020},  // R5 pos sub
        {64'hFFFF_FFFF_0080_0000, 1'b1, 10'h040},  // R5 smallest normal
        {64'hFFFF_FFFF_7F7F_FFFF, 1'b1, 10'h040},  // R5 largest finite
        {64'hFFFF_FFFF_7F80_0000, 1'b1, 10'h080},  // R5 +inf
        {64'hFFFF_FFFF_7F80_0001, 1'b1, 10'h100},  // R5 sNaN
        {64'hFFFF_FFFF_FFBF_FFFF, 1'b1, 10'h100},  // R5 neg sNaN
        {64'hFFFF_FFFF_7FC0_0000, 1'b1, 10'h200},  // R5 qNaN
        {64'h7FFF_FFFF_3F80_0000, 1'b1, 10'h200},  // R6 top bit clear
        {64'hFFFF_FFFE_FF80_0000, 1'b1, 10'h200},  // R6 low upper bit clear
        {64'h0000_0000_0000_0000, 1'b1, 10'h200},  // R6 zero register
        {64'hFFFE_FFFF_0000_0001, 1'b1, 10'h200}   // R6 middle bit clear
    };

    logic        clk;
    logic        rst_n;
    logic [63:0] src;
    logic        sgl;
    logic [31:0] bval;
    logic [63:0] cls;
    logic [63:0] boxed;

    int checks;
    int errors;
    bit done;

    fp_classify i_fp_classify (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .src_i     (src),
        .single_i  (sgl),
        .box_val_i (bval),
        .class_o   (cls),
        .boxed_o   (boxed)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] s, input logic g, input logic [31:0] b);
        @(negedge clk);
        src  = s;
        sgl  = g;
        bval = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [63:0] rnd;
        logic [63:0] held;
        rst_n = 1'b0;
        src   = 64'h7FF0_0000_0000_0000;
        sgl   = 1'b0;
        bval  = 32'h1234_5678;
        checks = 0;
        errors = 0;
        done   = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check64("R9 reset class", cls, 64'd0);
        check64("R9 reset boxed", boxed, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] b;
            b = VEC[i][42:11] ^ 32'(i * 32'h0101_0103);
            apply(VEC[i][74:11], VEC[i][10], b);
            check64("R1 R2 R3 R4 R5 R6 R7 vector class", cls, {54'd0, VEC[i][9:0]});
            check64("R8 vector boxed", boxed, {32'hFFFF_FFFF, b});
        end

        // R9: output holds between edges
        apply(64'h3FF0_0000_0000_0000, 1'b0, 32'hA5A5_A5A5);
        held = cls;
        @(negedge clk);
        src = 64'hFFF0_0000_0000_0000;
        #1;
        check64("R9 holds before edge", cls, held);
        @(posedge clk);
        #1;
        check64("R9 updates at edge", cls, 64'h001);

        // R10: pseudo-random registers in both modes
        rnd = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 300; k++) begin
            rnd = rnd ^ (rnd << 13);
            rnd = rnd ^ (rnd >> 7);
            rnd = rnd ^ (rnd << 17);
            apply(rnd, rnd[5], rnd[40:9]);
            checks++;
            if ($countones(cls[9:0]) != 1 || cls[63:10] != '0) begin
                errors++;
                $display("FAIL R10 one-hot actual=%h expected=one bit in 9:0", cls);
            end
            if (rnd[5] && rnd[63:32] != 32'hFFFF_FFFF)
                check64("R6 random bad box", cls, 64'h200);
        end

        // R5: random single with valid box matches double-free decode of low half
        apply({32'hFFFF_FFFF, 32'h4049_0FDB}, 1'b1, 32'h0);
        check64("R5 single normal", cls, 64'h040);

        // R9: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check64("R9 async reset class", cls, 64'd0);
        check64("R9 async reset boxed", boxed, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(64'h8000_0000_0000_0000, 1'b0, 32'hFFFF_0000);
        check64("R2 after reset", cls, 64'h008);
        check64("R8 after reset", boxed, 64'hFFFF_FFFF_FFFF_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule